// File: doc/BRIEF.md
# SD Host Word FIFO and Byte-Stream Data Engine

This block sits between a 32-bit register-style data interface and a byte-wide card data port. A 16-entry circular buffer of 32-bit words holds data in either direction. When a card read is in progress, bytes arriving from the card are assembled into words and queued for firmware to pop. When a card write is in progress, words pushed by firmware are split into bytes and sent to the card. At most one card byte moves per clock, under a valid/ready handshake.

Firmware loads a byte budget as the product of a block count and a per-block byte count. Each byte moved lowers the budget by one. Whenever the engine is re-evaluated with the budget at zero, it sets a data-done status bit and switches a state code to "data mode". It also sets one interrupt status bit for each source whose enable and command type match. Events that trigger re-evaluation are a data push or pop, a configuration write, a command issue, a budget load and a card byte move. A debug word reports the state code and the live buffer fill level.

Top module: `sdh_fifo_engine`

## Requirements
- R1: After reset the fill level, the state code, the status word and the interrupt line are all zero, neither card handshake is offered, and pop_data reads 0.
- R2: Pushed words are popped in push order. A push while 16 words are held is discarded. A pop while empty returns 0 and removes nothing.
- R3: dbg_word bits 8:4 always equal the number of words currently held in the buffer.
- R4: A pulse on blk_wr sets the byte budget to blk_blocks × blk_bytes. The engine moves exactly that many card bytes and then stops offering the card handshake.
- R5: During a read, the first card byte of each word lands in bits 7:0, the next in 15:8, and so on. A word is queued when its 4th byte arrives, or zero-padded when the budget runs out first. card_rx_ready is low while the buffer is full.
- R6: During a write, each popped word goes to the card low byte first. card_tx_valid is high only while the budget is nonzero and a byte is available.
- R7: When the engine is re-evaluated and the budget is zero, status bit 0 is set and the dbg_word state code (bits 3:0) becomes 1, one clock after the triggering event or final byte.
- R8: On completion, status bit 8 is set if the data-interrupt enable is on. Status bit 10 is set if the command requested busy-wait and the busy enable is on. Status bit 9 is set if the command is a write and the block enable is on. irq is the OR of status bits 10:8.
- R9: A pulse on sts_clr_wr clears every status bit whose bit is set in sts_clr_mask, and leaves the other bits unchanged.
- R10: A register pop in the same cycle as an engine word push leaves the fill level unchanged. A register push in the same cycle as an engine push is discarded.
- R11: The transfer direction is the read bit latched at the last command issue. When it is 0, card_rx_ready stays low. When it is 1, card_tx_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command issue pulse |
| cmd_is_read | input | 1 | Command moves data from card |
| cmd_is_write | input | 1 | Command moves data to card |
| cmd_busy | input | 1 | Command requests busy-wait |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_data_ie | input | 1 | Enable for status bit 8 |
| cfg_blk_ie | input | 1 | Enable for status bit 9 |
| cfg_busy_ie | input | 1 | Enable for status bit 10 |
| blk_wr | input | 1 | Budget load pulse |
| blk_blocks | input | 9 | Block count |
| blk_bytes | input | 12 | Bytes per block |
| push_wr | input | 1 | Data word push |
| push_data | input | 32 | Word to push |
| pop_rd | input | 1 | Data word pop |
| pop_data | output | 32 | Popped word, 0 if none |
| sts_clr_wr | input | 1 | Status clear pulse |
| sts_clr_mask | input | 11 | Bits of status to clear |
| status | output | 11 | Sticky status word |
| irq | output | 1 | Interrupt request |
| dbg_word | output | 9 | {fill level, state code} |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte in |
| card_rx_ready | output | 1 | Engine takes card byte |
| card_tx_valid | output | 1 | Engine offers card byte |
| card_tx_data | output | 8 | Card byte out |
| card_tx_ready | input | 1 | Card takes byte |

## Verification
Two buffer-port operations can coincide in one cycle. The engine can queue an assembled word in the same cycle that firmware pops one, and firmware can push a word in the same cycle that the engine queues its own. The bench provokes this after a long read has filled the buffer. It pops one word to make room, feeds three more bytes, and then delivers the word-completing byte with a register pop and a register push in that same clock. It judges the outcome by the fill level staying at 15, the popped value being the oldest word, and the later drain showing the engine's zero-padded-free final word with no trace of the pushed value.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    localparam int WORD_W = 32;
    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int STS_W = 11;

    localparam int STS_DONE     = 0;
    localparam int STS_DATA_IRQ = 8;
    localparam int STS_BLK_IRQ  = 9;
    localparam int STS_BUSY_IRQ = 10;

    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,
        PH_DATA = 4'd1
    } sdh_phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic busy;
    } xfer_cmd_t;

    typedef struct packed {
        logic data_ie;
        logic blk_ie;
        logic busy_ie;
    } irq_cfg_t;

    // Insert one byte into a word at lane idx (lane 0 = bits 7:0).
    function automatic logic [WORD_W-1:0] place_byte(
        input logic [WORD_W-1:0] word,
        input logic [$clog2(BYTES_PER_WORD)-1:0] idx,
        input logic [7:0] b
    );
        logic [WORD_W-1:0] r;
        r = word;
        r[idx*8 +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/sdh_word_fifo.sv
module sdh_word_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [DW-1:0]               wr_data,
    input  logic                        rd_en,
    output logic [DW-1:0]               rd_data,
    output logic [$clog2(DEPTH):0]      level,
    output logic                        full,
    output logic                        empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

endmodule

// File: rtl/sdh_byte_lane.sv
module sdh_byte_lane
    import sdh_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_value,
    input  logic              is_read,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              push_en,
    output logic [WORD_W-1:0] push_word,
    output logic              pop_en,
    output logic              moved,
    output logic              cnt_zero
);
    localparam int IW = $clog2(BYTES_PER_WORD);

    logic [CNT_W-1:0]  remain;
    logic [WORD_W-1:0] pack_q;
    logic [IW-1:0]     pack_idx;
    logic [WORD_W-1:0] hold_q;
    logic [IW-1:0]     hold_left;
    logic              rx_fire, tx_fire, last_byte;

    assign cnt_zero  = (remain == '0);
    assign last_byte = (remain == CNT_W'(1));

    assign rx_ready = is_read && !cnt_zero && !fifo_full;
    assign rx_fire  = rx_valid && rx_ready;

    assign tx_valid = !is_read && !cnt_zero && ((hold_left != '0) || !fifo_empty);
    assign tx_data  = (hold_left != '0) ? hold_q[7:0] : fifo_head[7:0];
    assign tx_fire  = tx_valid && tx_ready;

    assign push_word = place_byte(pack_q, pack_idx, rx_data);
    assign push_en   = rx_fire && ((pack_idx == IW'(BYTES_PER_WORD-1)) || last_byte);
    assign pop_en    = tx_fire && (hold_left == '0);
    assign moved     = rx_fire || tx_fire;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            remain    <= rst ? '0 : load_value;
            pack_q    <= '0;
            pack_idx  <= '0;
            hold_q    <= '0;
            hold_left <= '0;
        end else begin
            if (moved) remain <= remain - 1'b1;
            if (rx_fire) begin
                if (push_en) begin
                    pack_q   <= '0;
                    pack_idx <= '0;
                end else begin
                    pack_q   <= push_word;
                    pack_idx <= pack_idx + 1'b1;
                end
            end
            if (tx_fire) begin
                if (hold_left == '0) begin
                    hold_q    <= {8'h00, fifo_head[WORD_W-1:8]};
                    hold_left <= IW'(BYTES_PER_WORD-1);
                end else begin
                    hold_q    <= {8'h00, hold_q[WORD_W-1:8]};
                    hold_left <= hold_left - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdh_done_ctl.sv
module sdh_done_ctl
    import sdh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic             cnt_zero,
    input  xfer_cmd_t        cmd_q,
    input  irq_cfg_t         cfg_q,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_mask,
    output logic [STS_W-1:0] status,
    output logic [3:0]       phase_code
);
    logic             pend;
    logic             done;
    logic [STS_W-1:0] set_bits;
    logic [STS_W-1:0] keep_mask;
    sdh_phase_e       phase;

    assign done = pend && cnt_zero;

    always_comb begin
        set_bits = '0;
        if (done) begin
            set_bits[STS_DONE]     = 1'b1;
            set_bits[STS_DATA_IRQ] = cfg_q.data_ie;
            set_bits[STS_BUSY_IRQ] = cmd_q.busy && cfg_q.busy_ie;
            set_bits[STS_BLK_IRQ]  = cmd_q.wr && cfg_q.blk_ie;
        end
        keep_mask = clr_wr ? ~clr_mask : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            status <= '0;
            phase  <= PH_IDLE;
        end else begin
            pend   <= eval || (pend && !cnt_zero);
            status <= (status & keep_mask) | set_bits;
            if (done) phase <= PH_DATA;
        end
    end

    assign phase_code = phase;

endmodule

// File: rtl/sdh_fifo_engine.sv
module sdh_fifo_engine
    import sdh_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int BLK_W      = 9,
    parameter int LEN_W      = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_wr,
    input  logic                          cmd_is_read,
    input  logic                          cmd_is_write,
    input  logic                          cmd_busy,
    input  logic                          cfg_wr,
    input  logic                          cfg_data_ie,
    input  logic                          cfg_blk_ie,
    input  logic                          cfg_busy_ie,
    input  logic                          blk_wr,
    input  logic [BLK_W-1:0]              blk_blocks,
    input  logic [LEN_W-1:0]              blk_bytes,
    input  logic                          push_wr,
    input  logic [31:0]                   push_data,
    input  logic                          pop_rd,
    output logic [31:0]                   pop_data,
    input  logic                          sts_clr_wr,
    input  logic [10:0]                   sts_clr_mask,
    output logic [10:0]                   status,
    output logic                          irq,
    output logic [$clog2(FIFO_DEPTH)+4:0] dbg_word,
    input  logic                          card_rx_valid,
    input  logic [7:0]                    card_rx_data,
    output logic                          card_rx_ready,
    output logic                          card_tx_valid,
    output logic [7:0]                    card_tx_data,
    input  logic                          card_tx_ready
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
    localparam int CNT_W = BLK_W + LEN_W;

    xfer_cmd_t cmd_q;
    irq_cfg_t  cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cfg_q <= '0;
        end else begin
            if (cmd_wr) cmd_q <= '{rd: cmd_is_read, wr: cmd_is_write, busy: cmd_busy};
            if (cfg_wr) cfg_q <= '{data_ie: cfg_data_ie, blk_ie: cfg_blk_ie, busy_ie: cfg_busy_ie};
        end
    end

    logic              f_wr, f_rd, f_full, f_empty;
    logic [WORD_W-1:0] f_wdata, f_head;
    logic [LVL_W-1:0]  fifo_level;
    logic              eng_push, eng_pop, moved, cnt_zero;
    logic [WORD_W-1:0] eng_word;
    logic [CNT_W-1:0]  load_value;
    logic              reg_pop_ok;
    logic [3:0]        phase_code;

    assign load_value = CNT_W'(blk_blocks) * CNT_W'(blk_bytes);

    // Engine owns the buffer port when it needs it; register access yields.
    assign f_wr       = eng_push || push_wr;
    assign f_wdata    = eng_push ? eng_word : push_data;
    assign reg_pop_ok = pop_rd && !eng_pop && !f_empty;
    assign f_rd       = eng_pop || reg_pop_ok;
    assign pop_data   = reg_pop_ok ? f_head : '0;

    sdh_word_fifo #(.DEPTH(FIFO_DEPTH), .DW(WORD_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (f_wr),
        .wr_data (f_wdata),
        .rd_en   (f_rd),
        .rd_data (f_head),
        .level   (fifo_level),
        .full    (f_full),
        .empty   (f_empty)
    );

    sdh_byte_lane #(.CNT_W(CNT_W)) u_lane (
        .clk        (clk),
        .rst        (rst),
        .load       (blk_wr),
        .load_value (load_value),
        .is_read    (cmd_q.rd),
        .rx_valid   (card_rx_valid),
        .rx_data    (card_rx_data),
        .rx_ready   (card_rx_ready),
        .tx_valid   (card_tx_valid),
        .tx_data    (card_tx_data),
        .tx_ready   (card_tx_ready),
        .fifo_full  (f_full),
        .fifo_empty (f_empty),
        .fifo_head  (f_head),
        .push_en    (eng_push),
        .push_word  (eng_word),
        .pop_en     (eng_pop),
        .moved      (moved),
        .cnt_zero   (cnt_zero)
    );

    logic eval;
    assign eval = push_wr || pop_rd || cfg_wr || cmd_wr || blk_wr || moved;

    sdh_done_ctl u_done (
        .clk        (clk),
        .rst        (rst),
        .eval       (eval),
        .cnt_zero   (cnt_zero),
        .cmd_q      (cmd_q),
        .cfg_q      (cfg_q),
        .clr_wr     (sts_clr_wr),
        .clr_mask   (sts_clr_mask),
        .status     (status),
        .phase_code (phase_code)
    );

    assign irq      = |status[STS_BUSY_IRQ:STS_DATA_IRQ];
    assign dbg_word = {fifo_level, phase_code};

endmodule

// File: rtl/sdh_fifo_engine_chk.sv
module sdh_fifo_engine_chk #(
    parameter int FIFO_DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic [$clog2(FIFO_DEPTH):0] level,
    input logic                        push_wr,
    input logic                        pop_rd,
    input logic [31:0]                 pop_data,
    input logic                        tx_valid,
    input logic                        tx_ready,
    input logic                        rx_ready,
    input logic                        blk_wr,
    input logic [10:0]                 status,
    input logic                        cmd_wr_bit,
    input logic                        cmd_busy_bit,
    input logic                        cfg_blk_bit,
    input logic                        cfg_busy_bit
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(FIFO_DEPTH));

    p_drop_full_r2: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(FIFO_DEPTH)) && push_wr && !pop_rd && !(tx_valid && tx_ready)
        |=> level == LW'(FIFO_DEPTH));

    p_pop_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (level == '0) && pop_rd |-> pop_data == 32'h0);

    p_level_step_r3: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + 1'b1) ||
        (level + 1'b1 == $past(level)));

    p_quiet_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) && !$past(blk_wr) |-> !tx_valid && !rx_ready);

    p_blk_irq_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status[9]) |-> $past(cmd_wr_bit && cfg_blk_bit));

    p_busy_irq_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status[10]) |-> $past(cmd_busy_bit && cfg_busy_bit));

endmodule

bind sdh_fifo_engine sdh_fifo_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .level        (fifo_level),
    .push_wr      (push_wr),
    .pop_rd       (pop_rd),
    .pop_data     (pop_data),
    .tx_valid     (card_tx_valid),
    .tx_ready     (card_tx_ready),
    .rx_ready     (card_rx_ready),
    .blk_wr       (blk_wr),
    .status       (status),
    .cmd_wr_bit   (cmd_q.wr),
    .cmd_busy_bit (cmd_q.busy),
    .cfg_blk_bit  (cfg_q.blk_ie),
    .cfg_busy_bit (cfg_q.busy_ie)
);

// File: tb/sim_sdh_fifo_engine.sv
`timescale 1ns/1ps
module sim_sdh_fifo_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 0, cmd_is_read = 0, cmd_is_write = 0, cmd_busy = 0;
    logic        cfg_wr = 0, cfg_data_ie = 0, cfg_blk_ie = 0, cfg_busy_ie = 0;
    logic        blk_wr = 0;
    logic [8:0]  blk_blocks = '0;
    logic [11:0] blk_bytes = '0;
    logic        push_wr = 0;
    logic [31:0] push_data = '0;
    logic        pop_rd = 0;
    logic [31:0] pop_data;
    logic        sts_clr_wr = 0;
    logic [10:0] sts_clr_mask = '0;
    logic [10:0] status;
    logic        irq;
    logic [8:0]  dbg_word;
    logic        card_rx_valid = 0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready;
    logic        card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdh_fifo_engine u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just at a falling edge.
    task automatic issue_cmd(input logic rd, input logic wr, input logic busy);
        cmd_wr = 1; cmd_is_read = rd; cmd_is_write = wr; cmd_busy = busy;
        @(negedge clk); cmd_wr = 0;
    endtask

    task automatic set_cfg(input logic d, input logic b, input logic y);
        cfg_wr = 1; cfg_data_ie = d; cfg_blk_ie = b; cfg_busy_ie = y;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic load_blk(input int blocks, input int bytes);
        blk_wr = 1; blk_blocks = 9'(blocks); blk_bytes = 12'(bytes);
        @(negedge clk); blk_wr = 0;
    endtask

    task automatic push(input logic [31:0] w);
        push_wr = 1; push_data = w;
        @(negedge clk); push_wr = 0;
    endtask

    task automatic pop(output logic [31:0] w);
        pop_rd = 1; #1 w = pop_data;
        @(negedge clk); pop_rd = 0;
    endtask

    task automatic clear_all();
        repeat (2) @(negedge clk);
        sts_clr_wr = 1; sts_clr_mask = '1;
        @(negedge clk); sts_clr_wr = 0; sts_clr_mask = '0;
    endtask

    task automatic feed(input int base, input int step, input int n);
        int i = 0;
        int guard = 0;
        while (i < n && guard < 4 * n + 20) begin
            logic fire;
            card_rx_valid = 1; card_rx_data = 8'(base + i * step);
            #1 fire = card_rx_ready;
            @(negedge clk);
            if (fire) i++;
            guard++;
        end
        card_rx_valid = 0;
    endtask

    function automatic logic [31:0] seq_word(input int k);
        return {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
    endfunction

    task automatic t_reset();
        #1;
        chk("R1 level/phase", 32'(dbg_word), 32'h0);
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 pop_data", pop_data, 32'h0);
        chk("R1 rx_ready", 32'(card_rx_ready), 32'h0);
        chk("R1 tx_valid", 32'(card_tx_valid), 32'h0);
    endtask

    task automatic t_fifo();
        logic [31:0] w;
        push(32'hA000_0000);
        #1 chk("R3 level after one push", 32'(dbg_word[8:4]), 32'd1);
        for (int i = 1; i < 17; i++) push(32'hA000_0000 + 32'(i));
        #1 chk("R2 R3 level saturates at 16", 32'(dbg_word[8:4]), 32'd16);
        for (int i = 0; i < 16; i++) begin
            pop(w);
            chk("R2 pop order", w, 32'hA000_0000 + 32'(i));
        end
        pop(w);
        chk("R2 pop when empty", w, 32'h0);
        #1 chk("R3 level empty", 32'(dbg_word[8:4]), 32'd0);
    endtask

    task automatic t_read();
        logic [31:0] w;
        set_cfg(0, 0, 0);
        issue_cmd(1, 0, 0);
        clear_all();
        load_blk(2, 3);
        feed(8'h11, 8'h11, 6);
        card_rx_valid = 1;
        #1 chk("R4 rx_ready low after budget", 32'(card_rx_ready), 32'h0);
        chk("R7 done not before one clock", 32'(status[0]), 32'h0);
        @(negedge clk); card_rx_valid = 0;
        #1 chk("R7 done flag", 32'(status[0]), 32'h1);
        chk("R7 R3 debug word", 32'(dbg_word), 32'h21);
        pop(w); chk("R5 first word LSB first", w, 32'h4433_2211);
        pop(w); chk("R5 partial word zero padded", w, 32'h0000_6655);
    endtask

    task automatic t_write();
        logic [7:0] got [16];
        int ng = 0;
        set_cfg(0, 0, 0);
        issue_cmd(0, 1, 0);
        push(32'h4433_2211);
        push(32'h0000_6655);
        clear_all();
        load_blk(1, 6);
        card_tx_ready = 1;
        for (int c = 0; c < 14; c++) begin
            #1;
            if (c == 0) chk("R11 rx_ready low in write", 32'(card_rx_ready), 32'h0);
            if (card_tx_valid && ng < 16) begin got[ng] = card_tx_data; ng++; end
            @(negedge clk);
        end
        card_tx_ready = 0;
        chk("R4 R6 byte count", 32'(ng), 32'd6);
        for (int i = 0; i < 6; i++)
            chk("R6 byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
        #1 chk("R3 level drained", 32'(dbg_word[8:4]), 32'd0);
        chk("R7 done after write", 32'(status[0]), 32'h1);
    endtask

    task automatic t_irq();
        logic [31:0] w;
        set_cfg(1, 1, 1);
        issue_cmd(0, 1, 1);
        push(32'hCAFE_F00D);
        clear_all();
        load_blk(1, 4);
        card_tx_ready = 1;
        repeat (8) @(negedge clk);
        card_tx_ready = 0;
        #1 chk("R8 write+busy all enables", 32'(status), 32'h701);
        chk("R8 irq high", 32'(irq), 32'h1);
        sts_clr_wr = 1; sts_clr_mask = 11'h100;
        @(negedge clk); sts_clr_wr = 0;
        #1 chk("R9 clear bit 8 only", 32'(status), 32'h601);
        sts_clr_wr = 1; sts_clr_mask = 11'h600;
        @(negedge clk); sts_clr_wr = 0;
        #1 chk("R9 clear bits 10:9", 32'(status), 32'h001);
        chk("R8 irq low", 32'(irq), 32'h0);

        set_cfg(1, 1, 1);
        issue_cmd(1, 0, 0);
        clear_all();
        load_blk(1, 1);
        feed(8'h5A, 0, 1);
        @(negedge clk);
        #1 chk("R8 read with data enable", 32'(status), 32'h101);
        pop(w); chk("R5 single byte padded", w, 32'h0000_005A);

        set_cfg(0, 0, 0);
        clear_all();
        load_blk(1, 1);
        feed(8'h3C, 0, 1);
        @(negedge clk);
        #1 chk("R8 no enables", 32'(status), 32'h001);
        chk("R8 irq stays low", 32'(irq), 32'h0);
        pop(w);
    endtask

    task automatic t_full_concurrent();
        logic [31:0] w;
        set_cfg(0, 0, 0);
        issue_cmd(1, 0, 0);
        clear_all();
        load_blk(1, 68);
        feed(0, 1, 64);
        card_rx_valid = 1;
        #1 chk("R5 rx_ready low when full", 32'(card_rx_ready), 32'h0);
        chk("R3 level full", 32'(dbg_word[8:4]), 32'd16);
        card_rx_valid = 0;
        pop(w); chk("R2 oldest word", w, seq_word(0));
        feed(64, 1, 3);
        card_rx_valid = 1; card_rx_data = 8'd67;
        pop_rd = 1; push_wr = 1; push_data = 32'hDEAD_BEEF;
        #1 chk("R10 byte accepted", 32'(card_rx_ready), 32'h1);
        chk("R10 pop during engine push", pop_data, seq_word(1));
        @(negedge clk);
        card_rx_valid = 0; pop_rd = 0; push_wr = 0;
        #1 chk("R10 level unchanged", 32'(dbg_word[8:4]), 32'd15);
        for (int k = 2; k < 17; k++) begin
            pop(w); chk("R10 drain order", w, seq_word(k));
        end
        pop(w); chk("R10 pushed word discarded", w, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        @(negedge clk);
        t_fifo();
        t_read();
        t_write();
        t_irq();
        t_full_concurrent();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule